// File: doc/BRIEF.md
# Edge-Selectable 16-Pin GPIO Port

This block is a 16-pin general-purpose I/O port reached through a simple 16-bit register interface. Software sets each pin as an input or an output. Output pins drive the value held in the drive register. Input pins are brought through a two-flop synchronizer. A per-pin polarity bit picks one kind of edge, either rising or falling, and that edge is watched for on each input pin. Each detected edge on an unmasked input pin sets a sticky flag bit. Software clears flag bits by writing ones to them. A single interrupt line is high whenever any flag bit is set.

Each bus access is one cycle long: `bus_sel` is high, `bus_wr` gives the direction, and `bus_full` marks a full 16-bit access. A write takes effect at the clock edge that samples it. Read data is combinational from the current register state and is valid while `bus_sel` is high.

The interrupt line comes from a two-state machine. In state IRQ_QUIET the line is low. The transition IRQ_QUIET to IRQ_FLAGGED is taken when the next flag value has any bit set. The transition IRQ_FLAGGED to IRQ_QUIET is taken when the next flag value is all zero. In every other case the machine stays in its current state.

Top module: `gpio16_port`

## Requirements
- R1: After reset, the drive, direction, edge-polarity and mask registers each read 0xFFFF. The flag register and the synchronized input value read 0. `irq` is 0, and `pin_oe` and `pin_out` are 0.
- R2: The pin-level register at offset 0x00 returns `pin_in` as it was two clock edges earlier. Writes to offset 0x00 change no register.
- R3: The drive register is at offset 0x04 and the direction register is at offset 0x08. A direction bit of 1 makes the pin an input; 0 makes it an output. `pin_oe` equals the inverse of the direction register. `pin_out` equals the drive register ANDed with `pin_oe`. Both update at the edge that writes either register, so a pin that becomes an output at once drives its stored drive bit.
- R4: The edge-polarity register is at offset 0x0C. A bit value of 1 detects a low-to-high transition on that pin and 0 detects a high-to-low transition. The transition of the other polarity sets nothing. A pin change sampled at clock edge k shows up in the flag register after edge k+2.
- R5: The mask register is at offset 0x10. A flag bit is set only when its pin's direction bit is 1 and its mask bit is 0. A mask bit of 1 blocks the flag.
- R6: The flag register is at offset 0x14. A write clears exactly the bits written as 1. If a new edge arrives in the same cycle as a clear of that bit, the new edge wins and the bit ends up set.
- R7: `irq` is 1 exactly when the flag register is nonzero, in the same cycle.
- R8: An access with `bus_full` = 0 changes no register when it is a write, and returns 0 when it is a read.
- R9: Offsets other than 0x00, 0x04, 0x08, 0x0C, 0x10 and 0x14 read as 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_full | input | 1 | 1 = full 16-bit access |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Driven pin values |
| pin_oe | output | 16 | Per-pin output enable |
| irq | output | 1 | Interrupt, high while any flag bit is set |

## Verification
The timing of each result is fixed:
- A register write shows on `pin_out`, `pin_oe` and on readback just after the clock edge that samples it.
- A pin change driven before edge k reads back in the pin-level register after edge k+1.
- The same pin change sets its flag bit, and `irq` with it, after edge k+2.

The bench drives inputs at falling edges. It waits exactly that number of rising edges before it samples, 1 ns after a falling edge. The set-versus-clear case issues a clear so that it lands on edge k+2, the same edge at which the flag is set.

// File: rtl/gpio16_pkg.sv
`timescale 1ns/1ps
package gpio16_pkg;

    // Byte offsets decoded by the register file
    localparam int unsigned OFF_LEVEL = 'h00;
    localparam int unsigned OFF_DRIVE = 'h04;
    localparam int unsigned OFF_DIR   = 'h08;
    localparam int unsigned OFF_POL   = 'h0C;
    localparam int unsigned OFF_MASK  = 'h10;
    localparam int unsigned OFF_FLAG  = 'h14;

    typedef enum logic [2:0] {
        RSEL_NONE,
        RSEL_LEVEL,
        RSEL_DRIVE,
        RSEL_DIR,
        RSEL_POL,
        RSEL_MASK,
        RSEL_FLAG
    } rsel_e;

    typedef enum logic {
        IRQ_QUIET,
        IRQ_FLAGGED
    } irq_state_e;

endpackage

// File: rtl/gpio16_sync.sv
`timescale 1ns/1ps
module gpio16_sync #(
    parameter int W      = 16,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] sync_o,
    output logic [W-1:0] prev_o
);

    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain[0] <= '0;
        end else begin
            chain[0] <= raw_i;
        end
    end

    for (genvar gs = 1; gs < STAGES; gs++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain[gs] <= '0;
            end else begin
                chain[gs] <= chain[gs-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_o <= '0;
        end else begin
            prev_o <= chain[STAGES-1];
        end
    end

    assign sync_o = chain[STAGES-1];

endmodule

// File: rtl/gpio16_edge.sv
`timescale 1ns/1ps
module gpio16_edge #(
    parameter int W = 16
) (
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  logic [W-1:0] pol_i,
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] mask_i,
    output logic [W-1:0] hit_o
);

    for (genvar gp = 0; gp < W; gp++) begin : g_pin
        logic rise;
        logic fall;
        logic seen;
        assign rise = cur_i[gp] & ~prev_i[gp];
        assign fall = ~cur_i[gp] & prev_i[gp];
        assign seen = pol_i[gp] ? rise : fall;
        assign hit_o[gp] = seen & dir_i[gp] & ~mask_i[gp];
    end

endmodule

// File: rtl/gpio16_regs.sv
`timescale 1ns/1ps
module gpio16_regs
    import gpio16_pkg::*;
#(
    parameter int W      = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_full,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      level_i,
    input  logic [W-1:0]      hit_i,
    output logic [W-1:0]      drive_o,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      pol_o,
    output logic [W-1:0]      mask_o,
    output logic [W-1:0]      flag_o,
    output logic [W-1:0]      flag_next_o
);

    rsel_e        rsel;
    logic         acc_ok;
    logic         do_wr;
    logic         do_rd;
    logic [W-1:0] drive_q, dir_q, pol_q, mask_q, flag_q, flag_d;
    logic [W-1:0] clr_vec;

    always_comb begin
        rsel = RSEL_NONE;
        if      (bus_addr == ADDR_W'(OFF_LEVEL)) rsel = RSEL_LEVEL;
        else if (bus_addr == ADDR_W'(OFF_DRIVE)) rsel = RSEL_DRIVE;
        else if (bus_addr == ADDR_W'(OFF_DIR))   rsel = RSEL_DIR;
        else if (bus_addr == ADDR_W'(OFF_POL))   rsel = RSEL_POL;
        else if (bus_addr == ADDR_W'(OFF_MASK))  rsel = RSEL_MASK;
        else if (bus_addr == ADDR_W'(OFF_FLAG))  rsel = RSEL_FLAG;
    end

    assign acc_ok = bus_sel & bus_full;
    assign do_wr  = acc_ok & bus_wr;
    assign do_rd  = acc_ok & ~bus_wr;

    assign clr_vec = (do_wr && rsel == RSEL_FLAG) ? bus_wdata : '0;
    assign flag_d  = (flag_q & ~clr_vec) | hit_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            drive_q <= '1;
            dir_q   <= '1;
            pol_q   <= '1;
            mask_q  <= '1;
            flag_q  <= '0;
        end else begin
            if (do_wr) begin
                unique case (rsel)
                    RSEL_DRIVE: drive_q <= bus_wdata;
                    RSEL_DIR:   dir_q   <= bus_wdata;
                    RSEL_POL:   pol_q   <= bus_wdata;
                    RSEL_MASK:  mask_q  <= bus_wdata;
                    default:    ;
                endcase
            end
            flag_q <= flag_d;
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (do_rd) begin
            unique case (rsel)
                RSEL_LEVEL: bus_rdata = level_i;
                RSEL_DRIVE: bus_rdata = drive_q;
                RSEL_DIR:   bus_rdata = dir_q;
                RSEL_POL:   bus_rdata = pol_q;
                RSEL_MASK:  bus_rdata = mask_q;
                RSEL_FLAG:  bus_rdata = flag_q;
                default:    bus_rdata = '0;
            endcase
        end
    end

    assign drive_o     = drive_q;
    assign dir_o       = dir_q;
    assign pol_o       = pol_q;
    assign mask_o      = mask_q;
    assign flag_o      = flag_q;
    assign flag_next_o = flag_d;

    // R5: a newly set flag bit needs an unmasked input pin in the cycle before
    p_flag_needs_input_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((flag_q & ~$past(flag_q)) & ~$past(dir_q & ~mask_q)) == '0);

    // R6: a flag bit falls only where a one was written to the flag register
    p_clear_only_ones_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ((~flag_q & $past(flag_q)) & ~$past(clr_vec)) == '0);

    // R8: a narrow write leaves the configuration untouched
    p_narrow_write_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && !bus_full) |=>
            ($stable(drive_q) && $stable(dir_q) && $stable(pol_q) && $stable(mask_q)));

    // R9: a write to an unmapped offset leaves the configuration untouched
    p_unmapped_write_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && rsel == RSEL_NONE) |=>
            ($stable(drive_q) && $stable(dir_q) && $stable(pol_q) && $stable(mask_q)));

endmodule

// File: rtl/gpio16_port.sv
`timescale 1ns/1ps
module gpio16_port
    import gpio16_pkg::*;
#(
    parameter int W           = 16,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_full,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [W-1:0]      bus_wdata,
    output logic [W-1:0]      bus_rdata,
    input  logic [W-1:0]      pin_in,
    output logic [W-1:0]      pin_out,
    output logic [W-1:0]      pin_oe,
    output logic              irq
);

    logic [W-1:0] level, level_prev, hit;
    logic [W-1:0] drive, dir, pol, mask, flag, flag_next;
    irq_state_e   st_q, st_d;

    gpio16_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  (pin_in),
        .sync_o (level),
        .prev_o (level_prev)
    );

    gpio16_edge #(.W(W)) u_edge (
        .cur_i  (level),
        .prev_i (level_prev),
        .pol_i  (pol),
        .dir_i  (dir),
        .mask_i (mask),
        .hit_o  (hit)
    );

    gpio16_regs #(.W(W), .ADDR_W(ADDR_W)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_full    (bus_full),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .level_i     (level),
        .hit_i       (hit),
        .drive_o     (drive),
        .dir_o       (dir),
        .pol_o       (pol),
        .mask_o      (mask),
        .flag_o      (flag),
        .flag_next_o (flag_next)
    );

    assign pin_oe  = ~dir;
    assign pin_out = drive & ~dir;

    // Interrupt state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= IRQ_QUIET;
        end else begin
            st_q <= st_d;
        end
    end

    // Next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            IRQ_QUIET:   if (flag_next != '0) st_d = IRQ_FLAGGED;
            IRQ_FLAGGED: if (flag_next == '0) st_d = IRQ_QUIET;
            default:     st_d = IRQ_QUIET;
        endcase
    end

    // Output logic
    always_comb begin
        irq = (st_q == IRQ_FLAGGED);
    end

    // R7: the interrupt state agrees with the flag register
    p_irq_tracks_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (flag != '0));

    // R3: a full direction write shows on the enables at the next edge
    p_oe_after_dir_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_full && bus_addr == ADDR_W'(OFF_DIR)) |=>
            (pin_oe == ~$past(bus_wdata)));

endmodule

// File: tb/test_gpio16_port.sv
`timescale 1ns/1ps
module test_gpio16_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0, bus_full = 1'b1;
    logic [7:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] A_LVL = 8'h00, A_DRV = 8'h04, A_DIR = 8'h08,
                           A_POL = 8'h0C, A_MSK = 8'h10, A_FLG = 8'h14;

    always #2 clk = ~clk;

    gpio16_port i_gpio16_port (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_full(bus_full), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
        .pin_oe(pin_oe), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d, input logic full);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_full = full;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_full = 1'b1;
    endtask

    task automatic rd(input logic [7:0] a, input logic full, output logic [15:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a; bus_full = full;
        #1;
        d = bus_rdata;
        bus_sel = 1'b0; bus_full = 1'b1;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [15:0] exp);
        logic [15:0] d;
        rd(a, 1'b1, d);
        check(req, d, exp);
    endtask

    task automatic settle3();
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        #1;
        check("R1 irq", {15'b0, irq}, 16'h0);
        check("R1 pin_oe", pin_oe, 16'h0);
        check("R1 pin_out", pin_out, 16'h0);
        rd_chk("R1 drive", A_DRV, 16'hFFFF);
        rd_chk("R1 dir", A_DIR, 16'hFFFF);
        rd_chk("R1 pol", A_POL, 16'hFFFF);
        rd_chk("R1 mask", A_MSK, 16'hFFFF);
        rd_chk("R1 flag", A_FLG, 16'h0000);
        rd_chk("R1 level", A_LVL, 16'h0000);

        // R2 two-edge input delay and read-only level register
        @(negedge clk);
        pin_in = 16'h1234;
        @(posedge clk);
        rd_chk("R2 level after one edge", A_LVL, 16'h0000);
        rd_chk("R2 level after two edges", A_LVL, 16'h1234);
        wr(A_LVL, 16'h0000, 1'b1);
        rd_chk("R2 level unchanged by write", A_LVL, 16'h1234);
        rd_chk("R2 dir unchanged by level write", A_DIR, 16'hFFFF);
        rd_chk("R2 drive unchanged by level write", A_DRV, 16'hFFFF);
        @(negedge clk);
        pin_in = 16'h0000;
        settle3();

        // R8 narrow accesses
        wr(A_DIR, 16'h0000, 1'b0);
        rd_chk("R8 dir after narrow write", A_DIR, 16'hFFFF);
        check("R8 oe after narrow write", pin_oe, 16'h0000);
        rd(A_DIR, 1'b0, d);
        check("R8 narrow read", d, 16'h0000);

        // R9 unmapped offsets
        wr(8'h18, 16'h0000, 1'b1);
        wr(8'h02, 16'h0000, 1'b1);
        wr(8'h0A, 16'h0000, 1'b1);
        rd_chk("R9 unmapped read 0x18", 8'h18, 16'h0000);
        rd_chk("R9 unmapped read 0x02", 8'h02, 16'h0000);
        rd_chk("R9 drive kept", A_DRV, 16'hFFFF);
        rd_chk("R9 dir kept", A_DIR, 16'hFFFF);
        rd_chk("R9 pol kept", A_POL, 16'hFFFF);
        rd_chk("R9 mask kept", A_MSK, 16'hFFFF);

        // R3 output drive sweep: store while input, then turn one pin to output
        for (int i = 0; i < 16; i++) begin
            logic [15:0] pat;
            pat = 16'hA5C3 ^ 16'(i * 16'h1111);
            wr(A_DIR, 16'hFFFF, 1'b1);
            wr(A_DRV, pat, 1'b1);
            check("R3 no drive while input", pin_out, 16'h0000);
            wr(A_DIR, ~(16'h1 << i), 1'b1);
            #1;
            check("R3 oe single pin", pin_oe, 16'h1 << i);
            check("R3 stored bit driven", pin_out, pat & (16'h1 << i));
        end
        wr(A_DRV, 16'h3C5A, 1'b1);
        wr(A_DIR, 16'hFF00, 1'b1);
        #1;
        check("R3 oe low byte", pin_oe, 16'h00FF);
        check("R3 out low byte", pin_out, 16'h005A);
        wr(A_DIR, 16'hFFFF, 1'b1);

        // R4/R5 sweep: every pin, both polarities, all dir/mask combinations
        for (int i = 0; i < 16; i++) begin
            for (int e = 0; e < 2; e++) begin
                for (int c = 0; c < 4; c++) begin
                    logic [15:0] bit_i, dir_v, msk_v, expf;
                    logic dsel, msel;
                    bit_i = 16'h1 << i;
                    dsel  = c[0];
                    msel  = c[1];
                    wr(A_MSK, 16'hFFFF, 1'b1);
                    @(negedge clk);
                    pin_in = (e == 1) ? 16'h0000 : 16'hFFFF;
                    settle3();
                    wr(A_FLG, 16'hFFFF, 1'b1);
                    wr(A_POL, (e == 1) ? 16'hFFFF : 16'h0000, 1'b1);
                    dir_v = dsel ? 16'hFFFF : ~bit_i;
                    msk_v = msel ? bit_i : 16'h0000;
                    wr(A_DIR, dir_v, 1'b1);
                    wr(A_MSK, msk_v, 1'b1);
                    @(negedge clk);
                    pin_in = pin_in ^ bit_i;
                    settle3();
                    expf = (dsel && !msel) ? bit_i : 16'h0000;
                    rd_chk("R4/R5 selected edge flag", A_FLG, expf);
                    check("R7 irq with flag", {15'b0, irq}, {15'b0, (expf != 0)});
                    wr(A_FLG, 16'hFFFF, 1'b1);
                    @(negedge clk);
                    pin_in = pin_in ^ bit_i;
                    settle3();
                    rd_chk("R4 opposite edge ignored", A_FLG, 16'h0000);
                    check("R7 irq low", {15'b0, irq}, 16'h0);
                end
            end
        end

        // R6/R7 partial clear
        wr(A_MSK, 16'hFFFF, 1'b1);
        wr(A_DIR, 16'hFFFF, 1'b1);
        wr(A_POL, 16'hFFFF, 1'b1);
        @(negedge clk);
        pin_in = 16'h0000;
        settle3();
        wr(A_FLG, 16'hFFFF, 1'b1);
        wr(A_MSK, 16'h0000, 1'b1);
        @(negedge clk);
        pin_in = 16'h0003;
        settle3();
        rd_chk("R6 two flags", A_FLG, 16'h0003);
        check("R7 irq two flags", {15'b0, irq}, 16'h1);
        wr(A_FLG, 16'h0001, 1'b1);
        rd_chk("R6 one-bit clear", A_FLG, 16'h0002);
        check("R7 irq still high", {15'b0, irq}, 16'h1);
        wr(A_FLG, 16'h0000, 1'b1);
        rd_chk("R6 zero write keeps", A_FLG, 16'h0002);
        wr(A_FLG, 16'h0002, 1'b1);
        rd_chk("R6 last bit cleared", A_FLG, 16'h0000);
        check("R7 irq drops", {15'b0, irq}, 16'h0);

        // R6 set wins over clear in the same cycle
        @(negedge clk);
        pin_in = 16'h0007;
        @(posedge clk);
        @(posedge clk);
        wr(A_FLG, 16'hFFFF, 1'b1);
        rd_chk("R6 set beats clear", A_FLG, 16'h0004);
        check("R7 irq after collision", {15'b0, irq}, 16'h1);
        wr(A_FLG, 16'hFFFF, 1'b1);
        check("R7 irq final", {15'b0, irq}, 16'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule